// File: doc/BRIEF.md
# Bus Trace Record Filter

This block sits between a fabric snooper and a trace recorder. Every cycle it may see one observed fabric command, one combined response and one generic data word. For each of them it decides whether the record should be kept, and it answers with a one-cycle capture strobe. Formatting, storage and timestamps belong to other blocks.

Three pattern/mask groups do the selection. The type/size group looks at the command's transaction type and size. The tag group looks at the command's routing fields: group, chip, unit, scope, source and port. The response-code group looks at the response code. The type/size group and the response-code group each have their own invert control. A mask bit of 1 makes that bit take part in the compare, and a mask that is all zero lets every record through. Software loads the groups through a narrow register write port. A mode bit turns the 23-bit tag pattern/mask into a match on a generic data word. In that mode the command and response strobes stay quiet.

Top module: `trace_rec_filter`

## Requirements
- R1: Each strobe (`cmd_capture`, `rsp_capture`, `dat_capture`) is high for exactly the cycle after the clock edge that sampled the matching `*_valid` high with a keep decision. A strobe is never high without a valid in the previous cycle. All strobes are 0 after reset.
- R2: Inside a group, a bit whose mask is 0 is a don't-care. Only the bits whose mask is 1 must equal the pattern.
- R3: A group whose effective mask is all zero passes every record, and its invert control has no effect. After reset all masks are zero and all controls are clear, so every command and every response is captured.
- R4: The type/size group is a single 15-bit match over {size, type}. When its invert bit is set, it passes exactly the records that do not match.
- R5: The command tag is the 23-bit vector {group[3:0], chip[2:0], unit[9:0], scope[2:0], source[1:0], port}, with the group field at bit 22 and the port at bit 0. A command is kept only if the type/size group and the tag group (never inverted) both pass.
- R6: A response is kept when both the 5-bit response-code group (with its own invert) and the tag group pass. The source bits [2:1] are never compared for a response. The unit bits [15:6] are compared only when `rsp_local` is 1.
- R7: A command whose type is 7'h31 (miscellaneous) or 7'h3B (hang report) is kept without filtering, unless the filter-all control is set. When that control is set, such a command is filtered like any other.
- R8: A command with `cmd_own_write`=1 is dropped unless the own-write control is set. When that control is set, the command still has to pass the filters.
- R9: In data mode, `dat_word` is compared with the 23-bit tag pattern/mask and `cmd_capture` and `rsp_capture` stay 0. Outside data mode `dat_capture` stays 0.
- R10: A write with `cfg_we`=1 sets the configuration from the next clock edge. The address map is:
  - Address 0: [0] data mode, [1] filter-all, [2] own-write, [3] type/size invert, [4] response-code invert.
  - Address 1: type pattern [6:0] and size pattern [15:8].
  - Address 2: type mask [6:0] and size mask [15:8].
  - Address 3: tag pattern [22:0].
  - Address 4: tag mask [22:0].
  - Address 5: response-code pattern [4:0] and mask [12:8].
  
  Other addresses and bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_valid | input | 1 | Observed command present |
| cmd_type | input | 7 | Command transaction type |
| cmd_size | input | 8 | Command size |
| cmd_group | input | 4 | Command tag group ID |
| cmd_chip | input | 3 | Command tag chip ID |
| cmd_unit | input | 10 | Command tag unit ID |
| cmd_scope | input | 3 | Command scope |
| cmd_source | input | 2 | Command source |
| cmd_port | input | 1 | Command port |
| cmd_own_write | input | 1 | Command is a write issued by the trace unit itself |
| rsp_valid | input | 1 | Combined response present |
| rsp_code | input | 5 | Response code |
| rsp_group | input | 4 | Response tag group ID |
| rsp_chip | input | 3 | Response tag chip ID |
| rsp_unit | input | 10 | Response tag unit ID |
| rsp_scope | input | 3 | Response scope |
| rsp_port | input | 1 | Response port |
| rsp_local | input | 1 | Response belongs to a command from this chip |
| dat_valid | input | 1 | Generic data word present |
| dat_word | input | 23 | Generic data word |
| cmd_capture | output | 1 | Keep strobe for the command |
| rsp_capture | output | 1 | Keep strobe for the response |
| dat_capture | output | 1 | Keep strobe for the data word |

## Verification
All three strobes follow their valid by exactly one register, so a decision is due one clock edge after the input was presented. A configuration write lands at the edge that ends its write cycle, so any record presented after that cycle sees the new values. The bench drives every vector on a falling edge and compares the strobe at the next falling edge. That edge lies after the single rising edge that registers the decision and before the next stimulus can change it. The expected values come from a bench-side arithmetic model of the masked-compare rules, and the sweeps step through whole field ranges.

// File: rtl/trf_pkg.sv
package trf_pkg;
  localparam int TYPE_W   = 7;
  localparam int SIZE_W   = 8;
  localparam int GRP_W    = 4;
  localparam int CHIP_W   = 3;
  localparam int UNIT_W   = 10;
  localparam int SCOPE_W  = 3;
  localparam int SRC_W    = 2;
  localparam int PORT_W   = 1;
  localparam int RC_W     = 5;
  localparam int TS_W     = TYPE_W + SIZE_W;
  localparam int TAG_W    = GRP_W + CHIP_W + UNIT_W + SCOPE_W + SRC_W + PORT_W;
  localparam int CFG_AW   = 3;
  localparam int CFG_DW   = 32;

  localparam int SRC_LSB  = PORT_W;
  localparam int UNIT_LSB = PORT_W + SRC_W + SCOPE_W;
  localparam logic [TAG_W-1:0] SRC_FIELD  = TAG_W'(((1 << SRC_W) - 1) << SRC_LSB);
  localparam logic [TAG_W-1:0] UNIT_FIELD = TAG_W'(((1 << UNIT_W) - 1) << UNIT_LSB);

  typedef enum logic [CFG_AW-1:0] {
    CA_MODE   = 3'd0,
    CA_TS_PAT = 3'd1,
    CA_TS_MSK = 3'd2,
    CA_TG_PAT = 3'd3,
    CA_TG_MSK = 3'd4,
    CA_RC     = 3'd5
  } cfg_addr_e;

  typedef struct packed {
    logic              data_mode;
    logic              filter_all;
    logic              own_wr_en;
    logic              ts_inv;
    logic              rc_inv;
    logic [TYPE_W-1:0] type_pat;
    logic [TYPE_W-1:0] type_mask;
    logic [SIZE_W-1:0] size_pat;
    logic [SIZE_W-1:0] size_mask;
    logic [TAG_W-1:0]  tag_pat;
    logic [TAG_W-1:0]  tag_mask;
    logic [RC_W-1:0]   rc_pat;
    logic [RC_W-1:0]   rc_mask;
  } trf_cfg_t;
endpackage

// File: rtl/trf_mask_match.sv
module trf_mask_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] pat,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] value,
  input  logic         invert,
  output logic         pass
);
  logic [W-1:0] bit_miss;
  logic         hit;
  logic         empty;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_miss[i] = mask[i] & (pat[i] ^ value[i]);
  end

  assign hit   = ~|bit_miss;
  assign empty = ~|mask;
  assign pass  = empty | (hit ^ invert);
endmodule

// File: rtl/trf_cfg_regs.sv
module trf_cfg_regs
  import trf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output trf_cfg_t          cfg_q
);
  trf_cfg_t cfg_d;
  logic     upd_en;
  logic     wdata_unused;

  assign wdata_unused = ^wdata[CFG_DW-1:TAG_W];

  always_comb begin
    cfg_d  = cfg_q;
    upd_en = 1'b0;
    if (we) begin
      upd_en = 1'b1;
      case (cfg_addr_e'(addr))
        CA_MODE: begin
          cfg_d.data_mode  = wdata[0];
          cfg_d.filter_all = wdata[1];
          cfg_d.own_wr_en  = wdata[2];
          cfg_d.ts_inv     = wdata[3];
          cfg_d.rc_inv     = wdata[4];
        end
        CA_TS_PAT: begin
          cfg_d.type_pat = wdata[TYPE_W-1:0];
          cfg_d.size_pat = wdata[8 +: SIZE_W];
        end
        CA_TS_MSK: begin
          cfg_d.type_mask = wdata[TYPE_W-1:0];
          cfg_d.size_mask = wdata[8 +: SIZE_W];
        end
        CA_TG_PAT: cfg_d.tag_pat  = wdata[TAG_W-1:0];
        CA_TG_MSK: cfg_d.tag_mask = wdata[TAG_W-1:0];
        CA_RC: begin
          cfg_d.rc_pat  = wdata[RC_W-1:0];
          cfg_d.rc_mask = wdata[8 +: RC_W];
        end
        default: upd_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (upd_en) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/trace_rec_filter.sv
module trace_rec_filter
  import trf_pkg::*;
#(
  parameter logic [TYPE_W-1:0] MISC_TYPE = 7'h31,
  parameter logic [TYPE_W-1:0] HANG_TYPE = 7'h3B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  input  logic               cmd_valid,
  input  logic [TYPE_W-1:0]  cmd_type,
  input  logic [SIZE_W-1:0]  cmd_size,
  input  logic [GRP_W-1:0]   cmd_group,
  input  logic [CHIP_W-1:0]  cmd_chip,
  input  logic [UNIT_W-1:0]  cmd_unit,
  input  logic [SCOPE_W-1:0] cmd_scope,
  input  logic [SRC_W-1:0]   cmd_source,
  input  logic [PORT_W-1:0]  cmd_port,
  input  logic               cmd_own_write,
  input  logic               rsp_valid,
  input  logic [RC_W-1:0]    rsp_code,
  input  logic [GRP_W-1:0]   rsp_group,
  input  logic [CHIP_W-1:0]  rsp_chip,
  input  logic [UNIT_W-1:0]  rsp_unit,
  input  logic [SCOPE_W-1:0] rsp_scope,
  input  logic [PORT_W-1:0]  rsp_port,
  input  logic               rsp_local,
  input  logic               dat_valid,
  input  logic [TAG_W-1:0]   dat_word,
  output logic               cmd_capture,
  output logic               rsp_capture,
  output logic               dat_capture
);
  trf_cfg_t         cfg_q;
  logic [TAG_W-1:0] cmd_tag;
  logic [TAG_W-1:0] rsp_tag;
  logic [TAG_W-1:0] rsp_tag_mask;
  logic             ts_pass, cmd_tag_pass, rc_pass, rsp_tag_pass, dat_pass;
  logic             cmd_special, cmd_keep, rsp_keep, dat_keep;
  logic             cmd_cap_d, rsp_cap_d, dat_cap_d;

  trf_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  assign cmd_tag = {cmd_group, cmd_chip, cmd_unit, cmd_scope, cmd_source, cmd_port};
  assign rsp_tag = {rsp_group, rsp_chip, rsp_unit, rsp_scope, {SRC_W{1'b0}}, rsp_port};
  assign rsp_tag_mask = cfg_q.tag_mask & ~SRC_FIELD & (rsp_local ? {TAG_W{1'b1}} : ~UNIT_FIELD);

  trf_mask_match #(.W(TS_W)) u_cmd_ts (
    .pat    ({cfg_q.size_pat, cfg_q.type_pat}),
    .mask   ({cfg_q.size_mask, cfg_q.type_mask}),
    .value  ({cmd_size, cmd_type}),
    .invert (cfg_q.ts_inv),
    .pass   (ts_pass)
  );

  trf_mask_match #(.W(TAG_W)) u_cmd_tag (
    .pat    (cfg_q.tag_pat),
    .mask   (cfg_q.tag_mask),
    .value  (cmd_tag),
    .invert (1'b0),
    .pass   (cmd_tag_pass)
  );

  trf_mask_match #(.W(RC_W)) u_rsp_rc (
    .pat    (cfg_q.rc_pat),
    .mask   (cfg_q.rc_mask),
    .value  (rsp_code),
    .invert (cfg_q.rc_inv),
    .pass   (rc_pass)
  );

  trf_mask_match #(.W(TAG_W)) u_rsp_tag (
    .pat    (cfg_q.tag_pat),
    .mask   (rsp_tag_mask),
    .value  (rsp_tag),
    .invert (1'b0),
    .pass   (rsp_tag_pass)
  );

  trf_mask_match #(.W(TAG_W)) u_dat (
    .pat    (cfg_q.tag_pat),
    .mask   (cfg_q.tag_mask),
    .value  (dat_word),
    .invert (1'b0),
    .pass   (dat_pass)
  );

  always_comb begin
    cmd_special = (cmd_type == MISC_TYPE) || (cmd_type == HANG_TYPE);
    cmd_keep    = !cfg_q.data_mode
                  && (!cmd_own_write || cfg_q.own_wr_en)
                  && ((cmd_special && !cfg_q.filter_all) || (ts_pass && cmd_tag_pass));
    rsp_keep    = !cfg_q.data_mode && rc_pass && rsp_tag_pass;
    dat_keep    = cfg_q.data_mode && dat_pass;
    cmd_cap_d   = cmd_valid && cmd_keep;
    rsp_cap_d   = rsp_valid && rsp_keep;
    dat_cap_d   = dat_valid && dat_keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_capture <= 1'b0;
      rsp_capture <= 1'b0;
      dat_capture <= 1'b0;
    end else begin
      cmd_capture <= cmd_cap_d;
      rsp_capture <= rsp_cap_d;
      dat_capture <= dat_cap_d;
    end
  end
endmodule

// File: rtl/trf_chk.sv
module trf_chk
  import trf_pkg::*;
#(
  parameter logic [TYPE_W-1:0] MISC_TYPE = 7'h31,
  parameter logic [TYPE_W-1:0] HANG_TYPE = 7'h3B
) (
  input logic              clk,
  input logic              rst_n,
  input trf_cfg_t          cfg,
  input logic              cmd_valid,
  input logic [TYPE_W-1:0] cmd_type,
  input logic              cmd_own_write,
  input logic              rsp_valid,
  input logic              dat_valid,
  input logic              cmd_capture,
  input logic              rsp_capture,
  input logic              dat_capture
);
  AST_CMD_STROBE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_capture |-> $past(cmd_valid)); // R1
  AST_RSP_STROBE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_capture |-> $past(rsp_valid)); // R1
  AST_DAT_STROBE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dat_capture |-> $past(dat_valid)); // R1
  AST_FABRIC_QUIET_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.data_mode |=> !(cmd_capture || rsp_capture)); // R9
  AST_DATA_QUIET_IN_FABRIC: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.data_mode |=> !dat_capture); // R9
  AST_OWN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_own_write && !cfg.own_wr_en) |=> !cmd_capture); // R8
  AST_SPECIAL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cfg.data_mode && !cmd_own_write && !cfg.filter_all
     && (cmd_type == MISC_TYPE || cmd_type == HANG_TYPE)) |=> cmd_capture); // R7
  AST_EMPTY_MASKS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cfg.data_mode && !cmd_own_write && cfg.type_mask == '0
     && cfg.size_mask == '0 && cfg.tag_mask == '0) |=> cmd_capture); // R3
endmodule

bind trace_rec_filter trf_chk #(.MISC_TYPE(MISC_TYPE), .HANG_TYPE(HANG_TYPE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg           (cfg_q),
  .cmd_valid     (cmd_valid),
  .cmd_type      (cmd_type),
  .cmd_own_write (cmd_own_write),
  .rsp_valid     (rsp_valid),
  .dat_valid     (dat_valid),
  .cmd_capture   (cmd_capture),
  .rsp_capture   (rsp_capture),
  .dat_capture   (dat_capture)
);

// File: tb/trace_rec_filter_tb.sv
module trace_rec_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        cmd_valid;
  logic [6:0]  cmd_type;
  logic [7:0]  cmd_size;
  logic [3:0]  cmd_group;
  logic [2:0]  cmd_chip;
  logic [9:0]  cmd_unit;
  logic [2:0]  cmd_scope;
  logic [1:0]  cmd_source;
  logic [0:0]  cmd_port;
  logic        cmd_own_write;
  logic        rsp_valid;
  logic [4:0]  rsp_code;
  logic [3:0]  rsp_group;
  logic [2:0]  rsp_chip;
  logic [9:0]  rsp_unit;
  logic [2:0]  rsp_scope;
  logic [0:0]  rsp_port;
  logic        rsp_local;
  logic        dat_valid;
  logic [22:0] dat_word;
  logic        cmd_capture, rsp_capture, dat_capture;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // shadow configuration kept by the bench
  bit        m_data, m_fall, m_own, m_tsinv, m_rcinv;
  bit [6:0]  m_tpat, m_tmsk;
  bit [7:0]  m_spat, m_smsk;
  bit [22:0] m_gpat, m_gmsk;
  bit [4:0]  m_rpat, m_rmsk;

  always #4 clk = ~clk;

  trace_rec_filter u_dut (.*);

  function automatic bit mpass(bit [31:0] p, bit [31:0] m, bit [31:0] v, bit inv);
    if (m == 0) return 1'b1;
    return (((p ^ v) & m) == 0) ^ inv;
  endfunction

  function automatic bit exp_cmd(bit [6:0] t, bit [7:0] s, bit [22:0] g, bit own);
    if (m_data) return 1'b0;
    if (own && !m_own) return 1'b0;
    if ((t == 7'h31 || t == 7'h3B) && !m_fall) return 1'b1;
    return mpass({m_spat, m_tpat}, {m_smsk, m_tmsk}, {s, t}, m_tsinv)
           && mpass(m_gpat, m_gmsk, g, 1'b0);
  endfunction

  function automatic bit exp_rsp(bit [4:0] c, bit [22:0] g, bit loc);
    bit [22:0] em;
    if (m_data) return 1'b0;
    em = m_gmsk & ~23'h000006;
    if (!loc) em = em & ~23'h00FFC0;
    return mpass(m_rpat, m_rmsk, c, m_rcinv) && mpass(m_gpat, em, g, 1'b0);
  endfunction

  task automatic check(bit got, bit exp, string req, string what);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      3'd0: {m_rcinv, m_tsinv, m_own, m_fall, m_data} = d[4:0];
      3'd1: begin m_tpat = d[6:0]; m_spat = d[15:8]; end
      3'd2: begin m_tmsk = d[6:0]; m_smsk = d[15:8]; end
      3'd3: m_gpat = d[22:0];
      3'd4: m_gmsk = d[22:0];
      3'd5: begin m_rpat = d[4:0]; m_rmsk = d[12:8]; end
      default: ;
    endcase
  endtask

  task automatic run_cmd(bit [6:0] t, bit [7:0] s, bit [22:0] g, bit own, string req);
    bit e;
    e = exp_cmd(t, s, g, own);
    cmd_valid = 1'b1; cmd_type = t; cmd_size = s; cmd_own_write = own;
    {cmd_group, cmd_chip, cmd_unit, cmd_scope, cmd_source, cmd_port} = g;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_capture, e, req, $sformatf("cmd t=%h s=%h g=%h own=%0b", t, s, g, own));
    check(dat_capture, 1'b0, "R9", "dat strobe during command");
  endtask

  task automatic run_rsp(bit [4:0] c, bit [22:0] g, bit loc, string req);
    bit e;
    e = exp_rsp(c, g, loc);
    rsp_valid = 1'b1; rsp_code = c; rsp_local = loc;
    {rsp_group, rsp_chip, rsp_unit, rsp_scope} = g[22:3];
    rsp_port = g[0];
    @(negedge clk);
    rsp_valid = 1'b0;
    check(rsp_capture, e, req, $sformatf("rsp c=%h g=%h loc=%0b", c, g, loc));
  endtask

  task automatic run_dat(bit [22:0] w, string req);
    bit e;
    e = m_data && mpass(m_gpat, m_gmsk, w, 1'b0);
    dat_valid = 1'b1; dat_word = w;
    cmd_valid = 1'b1; rsp_valid = 1'b1;
    @(negedge clk);
    dat_valid = 1'b0; cmd_valid = 1'b0; rsp_valid = 1'b0;
    check(dat_capture, e, req, $sformatf("dat w=%h", w));
    if (m_data) begin
      check(cmd_capture, 1'b0, "R9", "cmd strobe in data mode");
      check(rsp_capture, 1'b0, "R9", "rsp strobe in data mode");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    cmd_valid = 0; cmd_type = 0; cmd_size = 0; cmd_group = 0; cmd_chip = 0;
    cmd_unit = 0; cmd_scope = 0; cmd_source = 0; cmd_port = 0; cmd_own_write = 0;
    rsp_valid = 0; rsp_code = 0; rsp_group = 0; rsp_chip = 0; rsp_unit = 0;
    rsp_scope = 0; rsp_port = 0; rsp_local = 0; dat_valid = 0; dat_word = 0;
    {m_data, m_fall, m_own, m_tsinv, m_rcinv} = '0;
    m_tpat = 0; m_tmsk = 0; m_spat = 0; m_smsk = 0;
    m_gpat = 0; m_gmsk = 0; m_rpat = 0; m_rmsk = 0;
    repeat (3) @(negedge clk);
    check(cmd_capture | rsp_capture | dat_capture, 1'b0, "R1", "strobes in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_capture | rsp_capture | dat_capture, 1'b0, "R1", "strobes after reset");

    // R3 / R10: reset configuration captures everything
    for (int i = 0; i < 16; i++) run_cmd(7'(i * 9), 8'(i * 17), 23'(i * 32'h5A5A5), 1'b0, "R3");
    for (int i = 0; i < 16; i++) run_rsp(5'(i * 3), 23'(i * 32'h3C3C3), i[0], "R3");
    // R3: invert with empty masks changes nothing
    wr(3'd0, 32'h18);
    for (int i = 0; i < 8; i++) run_cmd(7'(i * 5), 8'(i), 23'(i), 1'b0, "R3");
    for (int i = 0; i < 8; i++) run_rsp(5'(i * 4), 23'(i * 7), 1'b1, "R3");
    // R1: idle cycles give no strobe
    repeat (4) begin
      @(negedge clk);
      check(cmd_capture | rsp_capture | dat_capture, 1'b0, "R1", "idle strobe");
    end

    // R2 / R4: type sweep, partial mask, both invert settings
    wr(3'd1, 32'h0000_002A);
    wr(3'd2, 32'h0000_007C);
    for (int inv = 0; inv < 2; inv++) begin
      wr(3'd0, 32'(inv << 3));
      for (int t = 0; t < 128; t++) run_cmd(7'(t), 8'h55, 23'h0, 1'b0, "R4");
    end
    // R4: size sweep combined with a type that matches and one that does not
    wr(3'd1, 32'h0000_9A2A);
    wr(3'd2, 32'h0000_F37F);
    wr(3'd0, 32'h0);
    for (int s = 0; s < 256; s++) run_cmd(7'h2A, 8'(s), 23'h0, 1'b0, "R2");
    for (int s = 0; s < 256; s += 5) run_cmd(7'h2B, 8'(s), 23'h0, 1'b0, "R4");

    // R5: tag sweep over group and chip, then source/port/scope
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0052_0005);
    wr(3'd4, 32'h007F_0000);
    for (int gc = 0; gc < 128; gc++) run_cmd(7'h10, 8'h0, {7'(gc), 16'h1234}, 1'b0, "R5");
    wr(3'd4, 32'h0000_003F);
    for (int lo = 0; lo < 64; lo++) run_cmd(7'h11, 8'h3, {17'h1ABCD, 6'(lo)}, 1'b0, "R5");
    // R5: tag and type/size both required
    wr(3'd1, 32'h0000_0011);
    wr(3'd2, 32'h0000_007F);
    run_cmd(7'h11, 8'h0, 23'h5, 1'b0, "R5");
    run_cmd(7'h11, 8'h0, 23'h4, 1'b0, "R5");
    run_cmd(7'h12, 8'h0, 23'h5, 1'b0, "R5");

    // R6: response code sweep with both invert settings
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h0000_1B0A);
    for (int inv = 0; inv < 2; inv++) begin
      wr(3'd0, 32'(inv << 4));
      for (int c = 0; c < 32; c++) run_rsp(5'(c), 23'h0, 1'b1, "R6");
    end
    // R6: unit compared only for local responses, source never
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h0);
    wr(3'd3, 32'h0000_3FC0);
    wr(3'd4, 32'h0000_FFC6);
    for (int u = 0; u < 1024; u += 37) begin
      run_rsp(5'h1, {7'h0, 10'(u), 6'h0}, 1'b1, "R6");
      run_rsp(5'h1, {7'h0, 10'(u), 6'h0}, 1'b0, "R6");
    end
    run_rsp(5'h2, {7'h0, 10'h0FF, 6'h0}, 1'b1, "R6");
    run_rsp(5'h2, {7'h0, 10'h0FF, 6'h0}, 1'b0, "R6");

    // R7: miscellaneous and hang types with filter-all off then on
    wr(3'd1, 32'h0000_0000);
    wr(3'd2, 32'h0000_007F);
    for (int fa = 0; fa < 2; fa++) begin
      wr(3'd0, 32'(fa << 1));
      run_cmd(7'h31, 8'h0, 23'h0, 1'b0, "R7");
      run_cmd(7'h3B, 8'h0, 23'h0, 1'b0, "R7");
      run_cmd(7'h32, 8'h0, 23'h0, 1'b0, "R7");
      run_cmd(7'h00, 8'h0, 23'h0, 1'b0, "R7");
    end

    // R8: own writes dropped, then filtered when enabled
    for (int oe = 0; oe < 2; oe++) begin
      wr(3'd0, 32'(oe << 2));
      for (int t = 0; t < 4; t++) begin
        run_cmd(7'(t), 8'h0, 23'h0, 1'b1, "R8");
        run_cmd(7'h31, 8'h0, 23'h0, 1'b1, "R8");
      end
    end

    // R9: data mode sweep, then data words outside data mode
    wr(3'd3, 32'h0012_3456);
    wr(3'd4, 32'h0070_F00F);
    wr(3'd0, 32'h1);
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      run_dat(i[0] ? lfsr[30:8] : (23'h12_3456 ^ 23'(lfsr[3:0] << 4)), "R9");
    end
    wr(3'd4, 32'h0);
    for (int i = 0; i < 8; i++) run_dat(23'(i * 32'h11111), "R9");
    wr(3'd0, 32'h0);
    for (int i = 0; i < 8; i++) run_dat(23'(i * 32'h2345), "R9");

    // R10: writes to unused address have no effect
    wr(3'd4, 32'h007F_FFFF);
    wr(3'd3, 32'h0000_0000);
    wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    run_cmd(7'h05, 8'h0, 23'h0, 1'b0, "R10");
    run_cmd(7'h05, 8'h0, 23'h1, 1'b0, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule